// File: doc/BRIEF.md
# Keyed Configuration Window

This block lets boot firmware fetch small pieces of configuration data through two narrow registers. Firmware writes a 16-bit selector key into the control register and then reads the chosen entry one byte at a time from a byte-wide data register. Each read moves an internal cursor forward, so a blob of any length can be streamed through the same address. Entries sit in two banks, a generic bank and an architecture-local bank. Firmware picks the bank with a flag bit in the key.

A second flag bit in the key opens the entry for writing. Bytes written to the data register then fill the entry in order. The write that fills the last byte produces a one-cycle completion pulse tagged with the entry, and it rewinds the cursor. Every length and base address comes from a fixed descriptor table. All entry bytes live in a small on-chip store that is loaded at reset. A data read answers one cycle later with a valid strobe, which lets the store be a synchronous memory.

Top module: `keyed_cfg_window`

## Requirements
- R1: A control write with access size half (`ctl_size` = 2'b01) loads the selector key and clears the cursor to zero. Selecting again in the middle of an entry restarts that entry at byte 0.
- R2: A key whose index field, bits 13:0, is at or above `N_ENTRY` (default 8) selects an invalid entry. Reads of an invalid entry return zero and writes to it have no effect.
- R3: Key bit 15 picks the bank (0 = generic, 1 = architecture-local), and bits 13:0 index into that bank. The completion tag `done_index` is {bank bit, index}.
- R4: An accepted data read (`dat_re` with `dat_size` = 2'b00) raises `dat_rvalid` on the next cycle. `dat_rdata` then holds the byte at the cursor, and the cursor advances. Once the cursor reaches the entry length, or the entry has length zero, reads return zero.
- R5: A data write stores its byte at the cursor and advances the cursor only when key bit 14 is set and the cursor is below the entry length. Without bit 14 the write leaves both the data and the cursor unchanged.
- R6: The write that brings the cursor up to the entry length raises `done_pulse` for exactly one cycle, on the cycle after that write, with `done_index` naming the entry. The cursor then returns to zero.
- R7: The block ignores control writes of any size other than half and data accesses of any size other than byte. An ignored data read gives no `dat_rvalid`. `ctl_rdata` always reads zero.
- R8: After reset the block acts as if key 0 were selected with the cursor at zero.
- R9: Default contents, all multi-byte values least-significant byte first:
  - Generic 0: signature bytes 43 46 47 21.
  - Generic 1: 16 bytes, A0+i.
  - Generic 2: 16-bit value 0x0001.
  - Generic 3: 16-bit value 0x0004.
  - Generic 4: 6 zero bytes.
  - Local 0: 64-bit value 0x0123456789ABCDEF.
  - Local 1: 4 zero bytes.
  - All other entries have length 0.
- R10: A data read and a data write accepted in the same cycle perform the write. The read still returns `dat_rvalid` but with data zero.
- R11: A control write accepted in the same cycle as a data access drops the data access. If that access was a read, it returns zero with `dat_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_size | input | 2 | Control access size (00 byte, 01 half, 10 word, 11 double) |
| ctl_wdata | input | 16 | Selector key written to the control register |
| ctl_rdata | output | 16 | Control read data, always zero |
| dat_re | input | 1 | Data register read strobe |
| dat_we | input | 1 | Data register write strobe |
| dat_size | input | 2 | Data access size, same encoding as `ctl_size` |
| dat_wdata | input | 8 | Data write byte |
| dat_rdata | output | 8 | Data read byte, valid with `dat_rvalid` |
| dat_rvalid | output | 1 | Read response strobe, one cycle after an accepted read |
| done_pulse | output | 1 | Writable entry filled completely |
| done_index | output | 4 | {bank bit, entry index} of the filled entry |

## Verification
A wrong cursor shows up on the very next read response as a byte taken from the wrong position, or as zero where data was expected. Sweeping every entry past its end exposes off-by-one length errors within one response. A wrong bank or index decode returns another entry's bytes on the first read after selection. A bad write gate appears either as changed data on a later readback or as a completion pulse that is missing, early or mistagged in the cycle after the last write. Collision and select-priority faults show up on the response one cycle after the conflicting access.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int KEY_W     = 16;
    localparam int OFF_W     = 16;
    localparam int IDXF_W    = 14;
    localparam int BANK_BIT  = 15;
    localparam int WFLAG_BIT = 14;
    localparam logic [KEY_W-1:0] INVALID_KEY = 16'hFFFF;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;

    // default entry values
    localparam logic [31:0] SIG_WORD  = 32'h2147_4643;
    localparam logic [15:0] GFX_OFF   = 16'h0001;
    localparam logic [15:0] CPU_COUNT = 16'h0004;
    localparam logic [63:0] ARCH_WORD = 64'h0123_4567_89AB_CDEF;
    localparam int STORE_USED = 42;

    function automatic logic [OFF_W-1:0] ent_len(input logic bank, input int unsigned idx);
        logic [OFF_W-1:0] r;
        r = '0;
        if (!bank) begin
            case (idx)
                0: r = 16'd4;
                1: r = 16'd16;
                2: r = 16'd2;
                3: r = 16'd2;
                4: r = 16'd6;
                default: r = '0;
            endcase
        end else begin
            case (idx)
                0: r = 16'd8;
                1: r = 16'd4;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [OFF_W-1:0] ent_base(input logic bank, input int unsigned idx);
        logic [OFF_W-1:0] r;
        r = '0;
        if (!bank) begin
            case (idx)
                1: r = 16'd4;
                2: r = 16'd20;
                3: r = 16'd22;
                4: r = 16'd24;
                default: r = '0;
            endcase
        end else begin
            case (idx)
                0: r = 16'd30;
                1: r = 16'd38;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] init_byte(input int unsigned a);
        logic [7:0] r;
        if (a < 4)            r = SIG_WORD[8*a +: 8];
        else if (a < 20)      r = 8'(8'hA0 + (a - 4));
        else if (a < 22)      r = GFX_OFF[8*(a-20) +: 8];
        else if (a < 24)      r = CPU_COUNT[8*(a-22) +: 8];
        else if (a < 30)      r = 8'h00;
        else if (a < 38)      r = ARCH_WORD[8*(a-30) +: 8];
        else                  r = 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/cfgwin_desc.sv
module cfgwin_desc
    import cfgwin_pkg::*;
#(
    parameter int N_ENTRY = 8,
    localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic               bank_bit,
    input  logic [IDXF_W-1:0]  idx_field,
    output logic               ent_valid,
    output logic [IDX_W-1:0]   ent_idx,
    output logic [OFF_W-1:0]   ent_len_o,
    output logic [OFF_W-1:0]   ent_base_o
);
    always_comb begin
        ent_valid  = (32'(idx_field) < N_ENTRY);
        ent_idx    = idx_field[IDX_W-1:0];
        ent_len_o  = '0;
        ent_base_o = '0;
        if (ent_valid) begin
            ent_len_o  = ent_len(bank_bit, 32'(idx_field));
            ent_base_o = ent_base(bank_bit, 32'(idx_field));
        end
    end
endmodule

// File: rtl/cfgwin_store.sv
module cfgwin_store
    import cfgwin_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= init_byte(i);
            end
            rdata_q <= '0;
        end else begin
            if (we) begin
                mem_q[addr] <= wdata;
            end
            if (re) begin
                rdata_q <= mem_q[addr];
            end
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
    import cfgwin_pkg::*;
#(
    parameter int N_ENTRY = 8,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_size,
    input  logic [KEY_W-1:0]  ctl_wdata,
    input  logic              dat_re,
    input  logic              dat_we,
    input  logic [1:0]        dat_size,
    input  logic              ent_valid,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [OFF_W-1:0]  ent_len_i,
    input  logic [OFF_W-1:0]  ent_base_i,
    output logic [KEY_W-1:0]  key_o,
    output logic              ram_we,
    output logic              ram_re,
    output logic [AW-1:0]     ram_addr,
    output logic              rd_hit,
    output logic              rvalid,
    output logic              done,
    output logic [IDX_W:0]    done_idx
);
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [OFF_W-1:0] off;
        logic             rd_hit;
        logic             rvalid;
        logic             done;
        logic [IDX_W:0]   done_idx;
    } state_t;

    state_t st_d, st_q;
    logic ctl_acc, rd_acc, wr_acc, in_range, wflag;
    logic [OFF_W-1:0] off_inc;

    always_comb begin
        ctl_acc  = ctl_we && (ctl_size == SZ_HALF);
        rd_acc   = dat_re && (dat_size == SZ_BYTE);
        wr_acc   = dat_we && (dat_size == SZ_BYTE);
        wflag    = st_q.key[WFLAG_BIT];
        in_range = ent_valid && (st_q.off < ent_len_i);
        off_inc  = st_q.off + 1'b1;
        ram_addr = AW'(ent_base_i + st_q.off);
        ram_we   = 1'b0;
        ram_re   = 1'b0;

        st_d        = st_q;
        st_d.rd_hit = 1'b0;
        st_d.rvalid = rd_acc;
        st_d.done   = 1'b0;

        if (ctl_acc) begin
            st_d.off = '0;
            if (32'(ctl_wdata[IDXF_W-1:0]) >= N_ENTRY) begin
                st_d.key = INVALID_KEY;
            end else begin
                st_d.key = ctl_wdata;
            end
        end else if (wr_acc) begin
            if (wflag && in_range) begin
                ram_we = 1'b1;
                if (off_inc == ent_len_i) begin
                    st_d.off      = '0;
                    st_d.done     = 1'b1;
                    st_d.done_idx = {st_q.key[BANK_BIT], ent_idx};
                end else begin
                    st_d.off = off_inc;
                end
            end
        end else if (rd_acc) begin
            if (in_range) begin
                ram_re      = 1'b1;
                st_d.rd_hit = 1'b1;
                st_d.off    = off_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_o    = st_q.key;
    assign rd_hit   = st_q.rd_hit;
    assign rvalid   = st_q.rvalid;
    assign done     = st_q.done;
    assign done_idx = st_q.done_idx;
endmodule

// File: rtl/keyed_cfg_window.sv
module keyed_cfg_window
    import cfgwin_pkg::*;
#(
    parameter int N_ENTRY = 8,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_size,
    input  logic [15:0]       ctl_wdata,
    output logic [15:0]       ctl_rdata,
    input  logic              dat_re,
    input  logic              dat_we,
    input  logic [1:0]        dat_size,
    input  logic [7:0]        dat_wdata,
    output logic [7:0]        dat_rdata,
    output logic              dat_rvalid,
    output logic              done_pulse,
    output logic [IDX_W:0]    done_index
);
    logic [KEY_W-1:0] key;
    logic             ent_valid;
    logic [IDX_W-1:0] ent_idx;
    logic [OFF_W-1:0] ent_len_w, ent_base_w;
    logic             ram_we, ram_re, rd_hit;
    logic [AW-1:0]    ram_addr;
    logic [7:0]       ram_rdata;

    cfgwin_desc #(.N_ENTRY(N_ENTRY)) u_desc (
        .bank_bit  (key[BANK_BIT]),
        .idx_field (key[IDXF_W-1:0]),
        .ent_valid (ent_valid),
        .ent_idx   (ent_idx),
        .ent_len_o (ent_len_w),
        .ent_base_o(ent_base_w)
    );

    cfgwin_ctrl #(.N_ENTRY(N_ENTRY), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_size  (ctl_size),
        .ctl_wdata (ctl_wdata),
        .dat_re    (dat_re),
        .dat_we    (dat_we),
        .dat_size  (dat_size),
        .ent_valid (ent_valid),
        .ent_idx   (ent_idx),
        .ent_len_i (ent_len_w),
        .ent_base_i(ent_base_w),
        .key_o     (key),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_addr  (ram_addr),
        .rd_hit    (rd_hit),
        .rvalid    (dat_rvalid),
        .done      (done_pulse),
        .done_idx  (done_index)
    );

    cfgwin_store #(.DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .re   (ram_re),
        .addr (ram_addr),
        .wdata(dat_wdata),
        .rdata(ram_rdata)
    );

    assign dat_rdata = rd_hit ? ram_rdata : 8'h00;
    assign ctl_rdata = '0;
endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk
    import cfgwin_pkg::*;
#(
    parameter int N_ENTRY = 8,
    localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ctl_we,
    input logic [1:0]     ctl_size,
    input logic [15:0]    ctl_wdata,
    input logic           dat_re,
    input logic           dat_we,
    input logic [1:0]     dat_size,
    input logic [7:0]     dat_rdata,
    input logic           dat_rvalid,
    input logic           done_pulse,
    input logic [IDX_W:0] done_index
);
    logic ctl_acc, rd_acc, wr_acc;
    logic inv_q, wflag_q, bank_q;

    assign ctl_acc = ctl_we && (ctl_size == SZ_HALF);
    assign rd_acc  = dat_re && (dat_size == SZ_BYTE);
    assign wr_acc  = dat_we && (dat_size == SZ_BYTE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q   <= 1'b0;
            wflag_q <= 1'b0;
            bank_q  <= 1'b0;
        end else if (ctl_acc) begin
            inv_q   <= (32'(ctl_wdata[IDXF_W-1:0]) >= N_ENTRY);
            wflag_q <= ctl_wdata[WFLAG_BIT];
            bank_q  <= ctl_wdata[BANK_BIT];
        end
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_acc |=> dat_rvalid); // R4
    AST_NO_RVALID_UNREAD:  assert property (@(posedge clk) disable iff (!rst_n) !rd_acc |=> !dat_rvalid); // R7
    AST_INVALID_ZERO:      assert property (@(posedge clk) disable iff (!rst_n) (inv_q && rd_acc) |=> (dat_rdata == 8'h00)); // R2
    AST_COLLIDE_ZERO:      assert property (@(posedge clk) disable iff (!rst_n) (rd_acc && wr_acc) |=> (dat_rvalid && dat_rdata == 8'h00)); // R10
    AST_SELECT_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n) (ctl_acc && rd_acc) |=> (dat_rdata == 8'h00)); // R11
    AST_DONE_NEEDS_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) done_pulse |-> $past(wflag_q && !inv_q)); // R5
    AST_DONE_AFTER_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) done_pulse |-> $past(wr_acc && !ctl_acc)); // R6
    AST_DONE_BANK_TAG:     assert property (@(posedge clk) disable iff (!rst_n) done_pulse |-> (done_index[IDX_W] == $past(bank_q))); // R3
endmodule

bind keyed_cfg_window cfgwin_chk #(.N_ENTRY(N_ENTRY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_size  (ctl_size),
    .ctl_wdata (ctl_wdata),
    .dat_re    (dat_re),
    .dat_we    (dat_we),
    .dat_size  (dat_size),
    .dat_rdata (dat_rdata),
    .dat_rvalid(dat_rvalid),
    .done_pulse(done_pulse),
    .done_index(done_index)
);

// File: tb/sim_keyed_cfg_window.sv
`timescale 1ns/1ps
module sim_keyed_cfg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_size = 2'b01;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        dat_re = 1'b0;
    logic        dat_we = 1'b0;
    logic [1:0]  dat_size = 2'b00;
    logic [7:0]  dat_wdata = '0;
    logic [7:0]  dat_rdata;
    logic        dat_rvalid;
    logic        done_pulse;
    logic [3:0]  done_index;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [7:0] model [64];

    always #10 clk = ~clk;

    keyed_cfg_window u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_size(ctl_size), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .dat_re(dat_re), .dat_we(dat_we), .dat_size(dat_size), .dat_wdata(dat_wdata),
        .dat_rdata(dat_rdata), .dat_rvalid(dat_rvalid),
        .done_pulse(done_pulse), .done_index(done_index)
    );

    function automatic int exp_len(int bank, int idx);
        if (bank == 0) begin
            if (idx == 0) return 4;
            if (idx == 1) return 16;
            if (idx == 2 || idx == 3) return 2;
            if (idx == 4) return 6;
            return 0;
        end
        if (idx == 0) return 8;
        if (idx == 1) return 4;
        return 0;
    endfunction

    function automatic int exp_base(int bank, int idx);
        int b = 0;
        for (int i = 0; i < idx; i++) b += exp_len(0, i);
        if (bank == 1) begin
            b = 30;
            for (int i = 0; i < idx; i++) b += exp_len(1, i);
        end
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sel(input logic [15:0] key, input logic [1:0] sz = 2'b01);
        ctl_we = 1'b1; ctl_size = sz; ctl_wdata = key;
        @(posedge clk); @(negedge clk);
        ctl_we = 1'b0; ctl_size = 2'b01;
    endtask

    task automatic rd(input logic [7:0] exp, input string req);
        dat_re = 1'b1; dat_size = 2'b00;
        @(posedge clk); @(negedge clk);
        dat_re = 1'b0;
        chk(dat_rvalid === 1'b1 && dat_rdata === exp, req, {dat_rvalid, dat_rdata}, {1'b1, exp});
    endtask

    task automatic wr(input logic [7:0] d, input bit exp_done, input logic [3:0] exp_idx, input string req);
        dat_we = 1'b1; dat_size = 2'b00; dat_wdata = d;
        @(posedge clk); @(negedge clk);
        dat_we = 1'b0;
        if (exp_done)
            chk(done_pulse === 1'b1 && done_index === exp_idx, req, {done_pulse, done_index}, {1'b1, exp_idx});
        else
            chk(done_pulse === 1'b0, req, done_pulse, 0);
    endtask

    initial begin
        for (int a = 0; a < 64; a++) model[a] = 8'h00;
        model[0] = 8'h43; model[1] = 8'h46; model[2] = 8'h47; model[3] = 8'h21;
        for (int i = 0; i < 16; i++) model[4 + i] = 8'(8'hA0 + i);
        model[20] = 8'h01; model[21] = 8'h00;
        model[22] = 8'h04; model[23] = 8'h00;
        for (int i = 0; i < 8; i++) model[30 + i] = 8'((64'h0123_4567_89AB_CDEF >> (8 * i)) & 64'hFF);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dat_rvalid === 1'b0 && done_pulse === 1'b0, "R8 reset outputs", {dat_rvalid, done_pulse}, 0);
        // R8: key 0 selected after reset
        rd(8'h43, "R8 first byte after reset");
        chk(ctl_rdata === 16'h0, "R7 control read zero", ctl_rdata, 0);

        // R3 R4 R9 R2: sweep both banks, indices including invalid ones
        for (int bank = 0; bank < 2; bank++) begin
            for (int idx = 0; idx < 10; idx++) begin
                int len;
                int base;
                len  = (idx < 8) ? exp_len(bank, idx) : 0;
                base = exp_base(bank, idx);
                sel(16'((bank << 15) | idx));
                for (int k = 0; k < len + 2; k++) begin
                    rd((k < len) ? model[base + k] : 8'h00, "R4 R9 sweep byte");
                end
            end
        end

        // R1: reselect mid-stream restarts at byte 0
        sel(16'h0001);
        rd(8'hA0, "R1 entry1 b0");
        rd(8'hA1, "R1 entry1 b1");
        sel(16'h0001);
        rd(8'hA0, "R1 reselect restarts");

        // R5 R6: fill generic entry 4
        sel(16'h4004);
        for (int i = 0; i < 6; i++) begin
            wr(8'(8'h10 + i), i == 5, 4'b0100, "R6 done on last byte");
            model[24 + i] = 8'(8'h10 + i);
        end
        @(negedge clk);
        chk(done_pulse === 1'b0, "R6 done one cycle", done_pulse, 0);
        for (int i = 0; i < 6; i++) rd(model[24 + i], "R6 cursor rewound, R5 data stored");

        // R5: write without flag ignored
        sel(16'h0004);
        wr(8'hEE, 1'b0, 4'b0, "R5 no flag no done");
        rd(8'h10, "R5 no flag leaves data and cursor");

        // R3 R6: local bank entry 1
        sel(16'hC001);
        for (int i = 0; i < 4; i++) begin
            wr(8'(8'h50 + i), i == 3, 4'b1001, "R3 local bank done tag");
            model[38 + i] = 8'(8'h50 + i);
        end
        sel(16'h8001);
        for (int i = 0; i < 4; i++) rd(model[38 + i], "R3 local readback");

        // R2: write to invalid key
        sel(16'h4009);
        wr(8'h99, 1'b0, 4'b0, "R2 invalid write no done");
        rd(8'h00, "R2 invalid read zero");
        sel(16'h8008);
        rd(8'h00, "R2 index 8 invalid in local bank");

        // R7: size filtering
        sel(16'h0001);
        sel(16'h0000, 2'b00);
        sel(16'h0000, 2'b10);
        dat_re = 1'b1; dat_size = 2'b01;
        @(posedge clk); @(negedge clk);
        dat_re = 1'b0; dat_size = 2'b00;
        chk(dat_rvalid === 1'b0, "R7 half data read ignored", dat_rvalid, 0);
        rd(8'hA0, "R7 key and cursor unchanged");
        sel(16'h4004);
        dat_we = 1'b1; dat_size = 2'b10; dat_wdata = 8'h33;
        @(posedge clk); @(negedge clk);
        dat_we = 1'b0; dat_size = 2'b00;
        rd(model[24], "R7 word data write ignored");

        // R10: collision
        sel(16'h4004);
        dat_re = 1'b1; dat_we = 1'b1; dat_size = 2'b00; dat_wdata = 8'h77;
        @(posedge clk); @(negedge clk);
        dat_re = 1'b0; dat_we = 1'b0;
        chk(dat_rvalid === 1'b1 && dat_rdata === 8'h00, "R10 collision read zero", {dat_rvalid, dat_rdata}, 9'h100);
        model[24] = 8'h77;
        sel(16'h0004);
        rd(8'h77, "R10 write performed");

        // R11: select with data read in same cycle
        sel(16'h0000);
        ctl_we = 1'b1; ctl_size = 2'b01; ctl_wdata = 16'h0001; dat_re = 1'b1;
        @(posedge clk); @(negedge clk);
        ctl_we = 1'b0; dat_re = 1'b0;
        chk(dat_rvalid === 1'b1 && dat_rdata === 8'h00, "R11 read dropped", {dat_rvalid, dat_rdata}, 9'h100);
        rd(8'hA0, "R11 new key from byte 0");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule